// File: doc/BRIEF.md
# Page-Buffered Flash Program Sequencer

This block models the program engine of an embedded flash array. The array is held in on-chip RAM and organised as pages of words. A host first places between one and a full page of words into per-slot page latches. It then issues a program command that names the target page. The engine clears the whole page to all ones for a fixed erase interval, then commits every latched word during a fixed write interval. A ready output stays low for the whole operation.

A chip-wide erase sets every word to all ones. A program command may skip the page erase, which makes the operation only the write interval long. In that case each stored word becomes the AND of its old value and the new data, because programming can only clear bits. Reads are combinational and are served whenever the engine is idle, including while words are being loaded.

Durations are counted in clock cycles through parameters. The default geometry is 16 pages of 64 words of 32 bits. The full-size array of 1024 pages needs `PAGES=1024` and a `CHIP_CYCLES` of at least 65536.

Top module: `flash_page_prog`

## Requirements
- R1: `ce_en` while ready makes `ready` low for exactly CHIP_CYCLES cycles, starting the cycle after the command. Afterwards every word reads 32'hFFFFFFFF.
- R2: `pg_en` with `pg_skip`=0 while ready makes `ready` low for exactly ERASE_CYCLES+WRITE_CYCLES cycles, starting the cycle after the command. Without a command, `ready` stays high.
- R3: After a program with erase, each loaded slot of the page reads back its latched data and each slot not loaded reads all ones.
- R4: `pg_en` with `pg_skip`=1 keeps `ready` low for WRITE_CYCLES cycles. Each loaded slot then holds the old word ANDed with the latched data.
- R5: All slot valid flags clear when an operation ends, so a following skip-erase program with no new loads leaves the page unchanged.
- R6: While ready, `rd_data` equals the word at `rd_addr` = {page, slot} in the same cycle, also during a load. Such a read does not raise `err`.
- R7: While busy, `rd_data` is all ones, and a read request makes `err` high in the next cycle.
- R8: A load, program or chip-erase command issued while busy has no effect on the array, latches or timing, and raises `err` in the next cycle.
- R9: A load presented in the same cycle as the program command is included in that program.
- R10: After reset, `ready` is high and `err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load one word into a page latch slot |
| ld_slot | input | 6 | Slot index for the load |
| ld_data | input | 32 | Word to latch |
| pg_en | input | 1 | Start a page program |
| pg_page | input | 4 | Target page |
| pg_skip | input | 1 | 1: skip the page erase (write only) |
| ce_en | input | 1 | Start a chip-wide erase |
| rd_en | input | 1 | Read request (used for the busy error flag) |
| rd_addr | input | 10 | Word address {page, slot} |
| rd_data | output | 32 | Read data, all ones while busy |
| ready | output | 1 | High when idle, low during an operation |
| err | output | 1 | Pulses the cycle after a request made while busy |

## Verification
A slot load and a program command can arrive in the same cycle. So can a read and a load. The bench drives `ld_en` and `pg_en` on the same edge and then reads the slot back after the write, expecting the new data. It also reads a known word while a load is in flight and expects that word with `err` low. A read and a program command landing together is judged the same way: the read is still served because `ready` only falls on the next cycle.

// File: rtl/flash_page_prog.sv
module flash_page_prog #(
  parameter int PAGES        = 16,
  parameter int WORDS        = 64,
  parameter int WIDTH        = 32,
  parameter int ERASE_CYCLES = 80,
  parameter int WRITE_CYCLES = 80,
  parameter int CHIP_CYCLES  = 1200,
  localparam int LW = $clog2(WORDS),
  localparam int PW = $clog2(PAGES),
  localparam int AW = LW + PW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [LW-1:0]    ld_slot,
  input  logic [WIDTH-1:0] ld_data,
  input  logic             pg_en,
  input  logic [PW-1:0]    pg_page,
  input  logic             pg_skip,
  input  logic             ce_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  output logic             ready,
  output logic             err
);
  localparam int TOTAL = PAGES * WORDS;
  localparam int TW = $clog2(CHIP_CYCLES + ERASE_CYCLES + WRITE_CYCLES + 1);
  localparam logic [AW:0] NW = (AW+1)'(WORDS);
  localparam logic [AW:0] NT = (AW+1)'(TOTAL);

  typedef enum logic [1:0] {S_IDLE, S_ERASE, S_WRITE, S_CHIP} st_t;

  st_t              st;
  logic [WIDTH-1:0] mem [TOTAL];
  logic [WIDTH-1:0] lat [WORDS];
  logic [WORDS-1:0] vld;
  logic [PW-1:0]    pg_r;
  logic [TW-1:0]    tmr;
  logic [AW:0]      sc;
  logic             we;
  logic [AW-1:0]    wa;
  logic [WIDTH-1:0] wd;

  wire           idle    = (st == S_IDLE);
  wire [LW-1:0]  slot    = sc[LW-1:0];
  wire [AW-1:0]  pg_addr = {pg_r, slot};

  assign ready   = idle;
  assign rd_data = idle ? mem[rd_addr] : '1;

  always_comb begin
    we = 1'b0;
    wa = pg_addr;
    wd = '1;
    case (st)
      S_ERASE: we = (sc < NW);
      S_WRITE: begin
        we = (sc < NW) && vld[slot];
        wd = mem[pg_addr] & lat[slot];
      end
      S_CHIP: begin
        we = (sc < NT);
        wa = sc[AW-1:0];
      end
      default: we = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (idle && ld_en) lat[ld_slot] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      vld  <= '0;
      pg_r <= '0;
      tmr  <= '0;
      sc   <= '0;
      err  <= 1'b0;
    end else begin
      err <= !idle && (ld_en || pg_en || ce_en || rd_en);
      if (idle) begin
        sc <= '0;
        if (ld_en) vld[ld_slot] <= 1'b1;
        if (ce_en) begin
          st  <= S_CHIP;
          tmr <= TW'(CHIP_CYCLES - 1);
        end else if (pg_en) begin
          pg_r <= pg_page;
          if (pg_skip) begin
            st  <= S_WRITE;
            tmr <= TW'(WRITE_CYCLES - 1);
          end else begin
            st  <= S_ERASE;
            tmr <= TW'(ERASE_CYCLES - 1);
          end
        end
      end else begin
        if (sc != '1) sc <= sc + 1'b1;
        if (tmr == '0) begin
          if (st == S_ERASE) begin
            st  <= S_WRITE;
            tmr <= TW'(WRITE_CYCLES - 1);
            sc  <= '0;
          end else begin
            st  <= S_IDLE;
            vld <= '0;
          end
        end else begin
          tmr <= tmr - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flash_page_prog_chk.sv
module flash_page_prog_chk (
  input logic clk,
  input logic rst_n,
  input logic ld_en,
  input logic pg_en,
  input logic ce_en,
  input logic rd_en,
  input logic ready,
  input logic err
);
  assert_hold_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !pg_en && !ce_en |=> ready);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready && (pg_en || ce_en) |=> !ready);

  assert_busy_read_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ready && rd_en |=> err);

  assert_busy_cmd_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready && (ld_en || pg_en || ce_en) |=> err);

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(!ready));
endmodule

bind flash_page_prog flash_page_prog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .pg_en(pg_en),
  .ce_en(ce_en), .rd_en(rd_en), .ready(ready), .err(err)
);

// File: tb/flash_page_prog_bench.sv
module flash_page_prog_bench;
  localparam int E = 80, W = 80, C = 1200;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 0, rst_n = 0;
  logic ld_en = 0, pg_en = 0, pg_skip = 0, ce_en = 0, rd_en = 0;
  logic [5:0] ld_slot = '0;
  logic [31:0] ld_data = '0;
  logic [3:0] pg_page = '0;
  logic [9:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic ready, err;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  flash_page_prog u_flash_page_prog (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_slot(ld_slot), .ld_data(ld_data),
    .pg_en(pg_en), .pg_page(pg_page), .pg_skip(pg_skip), .ce_en(ce_en),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready), .err(err)
  );

  // {page[41:38], slot[37:32], data[31:0]}
  localparam logic [41:0] VEC [6] = '{
    {4'd0,  6'd0,  32'h0000_0000},
    {4'd1,  6'd5,  32'hDEAD_BEEF},
    {4'd2,  6'd62, 32'h1234_5678},
    {4'd4,  6'd17, 32'hA5A5_5A5A},
    {4'd10, 6'd33, 32'hFFFF_0000},
    {4'd11, 6'd1,  32'h0F0F_F0F0}
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic rd(input string r, input logic [3:0] p, input logic [5:0] s, input logic [31:0] exp);
    rd_addr = {p, s};
    rd_en = 1;
    #1;
    chk(r, rd_data, exp);
    rd_en = 0;
  endtask

  task automatic load(input logic [5:0] s, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1; ld_slot = s; ld_data = d;
    @(negedge clk);
    ld_en = 0;
  endtask

  // inj: 0 none, 1 load slot 7, 2 read, 3 program, 4 chip erase
  task automatic run(input logic ce, input logic [3:0] p, input logic s, input int inj, output int cnt);
    @(negedge clk);
    if (ce) ce_en = 1; else begin pg_en = 1; pg_page = p; pg_skip = s; end
    @(negedge clk);
    ce_en = 0; pg_en = 0;
    cnt = 0;
    while (!ready && cnt < 5000) begin
      cnt++;
      if (cnt == 5) begin
        case (inj)
          1: begin ld_en = 1; ld_slot = 6'd7; ld_data = 32'h0; end
          2: begin rd_en = 1; rd_addr = 10'd0; #1; chk("R7 busy read data", rd_data, ONES); end
          3: begin pg_en = 1; pg_page = 4'd9; pg_skip = 1; end
          4: ce_en = 1;
          default: ;
        endcase
      end
      if (cnt == 6) begin
        ld_en = 0; rd_en = 0; pg_en = 0; ce_en = 0;
        if (inj == 2) chk("R7 err after busy read", {31'd0, err}, 32'd1);
        else if (inj != 0) chk("R8 err after busy command", {31'd0, err}, 32'd1);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 ready after reset", {31'd0, ready}, 32'd1);
    chk("R10 err after reset", {31'd0, err}, 32'd0);

    run(1, 0, 0, 0, cnt);
    chk("R1 chip erase busy cycles", cnt, C);
    rd("R1 erased word", 0, 0, ONES);
    rd("R1 erased word", 7, 45, ONES);
    rd("R1 erased word", 15, 63, ONES);

    foreach (VEC[i]) begin
      load(VEC[i][37:32], VEC[i][31:0]);
      run(0, VEC[i][41:38], 0, 0, cnt);
      chk("R2 program busy cycles", cnt, E + W);
      rd("R3 loaded word", VEC[i][41:38], VEC[i][37:32], VEC[i][31:0]);
      rd("R3 unloaded word", VEC[i][41:38], VEC[i][37:32] ^ 6'd1, ONES);
    end

    load(0, 32'h1111_1111); load(10, 32'h2222_2222); load(63, 32'h3333_3333);
    run(0, 3, 0, 0, cnt);
    rd("R3 multi slot 0", 3, 0, 32'h1111_1111);
    rd("R3 multi slot 10", 3, 10, 32'h2222_2222);
    rd("R3 multi slot 63", 3, 63, 32'h3333_3333);
    rd("R3 multi slot 1", 3, 1, ONES);

    load(2, 32'hF0F0_FFFF);
    run(0, 5, 0, 0, cnt);
    load(2, 32'hFFFF_00FF);
    run(0, 5, 1, 2, cnt);
    chk("R4 skip-erase busy cycles", cnt, W);
    rd("R4 AND of old and new", 5, 2, 32'hF0F0_00FF);

    run(0, 5, 1, 3, cnt);
    chk("R8 busy program does not extend", cnt, W);
    rd("R5 no reload leaves page", 5, 2, 32'hF0F0_00FF);

    run(0, 6, 1, 1, cnt);
    rd("R8 busy load ignored", 6, 7, ONES);

    load(0, 32'h1234_5678);
    run(0, 9, 0, 4, cnt);
    chk("R8 busy chip erase timing", cnt, E + W);
    rd("R8 busy chip erase ignored", 1, 5, 32'hDEAD_BEEF);
    rd("R8 programmed word kept", 9, 0, 32'h1234_5678);

    @(negedge clk);
    ld_en = 1; ld_slot = 6'd4; ld_data = 32'hCAFE_0001;
    rd("R6 read during load", 2, 62, 32'h1234_5678);
    rd_en = 1;
    @(negedge clk);
    ld_en = 0; rd_en = 0;
    chk("R6 no err on idle read", {31'd0, err}, 32'd0);

    @(negedge clk);
    ld_en = 1; ld_slot = 6'd9; ld_data = 32'h0BAD_F00D;
    pg_en = 1; pg_page = 4'd8; pg_skip = 0;
    rd("R9 read on program cycle", 4, 17, 32'hA5A5_5A5A);
    @(negedge clk);
    ld_en = 0; pg_en = 0;
    cnt = 0;
    while (!ready && cnt < 5000) begin cnt++; @(negedge clk); end
    chk("R9 busy cycles", cnt, E + W);
    rd("R9 same-cycle load written", 8, 9, 32'h0BAD_F00D);
    rd("R9 earlier load also written", 8, 4, 32'hCAFE_0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule